// File: doc/BRIEF.md
# Processor System-Control Mode and Software-Interrupt Unit

This block holds the processor's mode/status word and its cause word, together with a small bank of plain system-control registers. The pipeline writes it through a move-to-control-register port (5-bit index, 32-bit data) and reads it through a combinational read port. A return-from-exception strobe pops a three-level stack of kernel-mode and interrupt-enable bit pairs kept in the six low bits of the status word. An exception-entry strobe pushes that stack.

A write to the status or cause word rearms a software-interrupt check. A small state machine has two states, `ST_IDLE` and `ST_EVAL`. Transition T1 goes from `ST_IDLE` to `ST_EVAL` on a write to index 12 or 13. Transition T2 keeps `ST_EVAL` when another such write arrives. Transition T3 returns from `ST_EVAL` to `ST_IDLE` otherwise. While the machine is in `ST_EVAL`, it tests the freshly written registers. If the status enable bit 0 is set and `status & cause & 0x300` is nonzero, it raises an exception request for one cycle. The request carries a branch-delay-slot flag, captured with the write, and the current cause word.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the status word, the cause word and every stored register read zero, and no exception request is raised.
- R2: A write to index 12 replaces the whole status word, and a read of index 12 returns it.
- R3: A write to index 13 stores the data with bits 15..10 forced to zero, so reads of index 13 always show zeros there.
- R4: Indices other than 12 and 13 below NUM_REGS (default 16) store and return the written word. Indices at or above NUM_REGS read zero, and writes to them have no effect.
- R5: A return-from-exception strobe keeps status bits 31..4 and loads bits 3..0 with the old bits 5..2.
- R6: An exception-entry strobe keeps status bits 31..6, moves old bits 3..0 into bits 5..2, and clears bits 1..0.
- R7: In the same cycle, exception entry wins over return-from-exception, which wins over a register write to the status word. A losing status write is dropped.
- R8: In the cycle after a write to index 12 or 13, `exc_req_o` is high exactly when status bit 0 is set and status AND cause AND 0x300 is nonzero. It is low in every other case.
- R9: While the request is high, `exc_slot_o` equals the `slot_i` value that came with the triggering write. `exc_slot_o` is zero otherwise. `exc_cause_o` always shows the stored cause word.
- R10: The request is a single-cycle pulse unless a further write to index 12 or 13 follows back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register write index |
| wr_data | input | 32 | Register write data |
| slot_i | input | 1 | Writing instruction sits in a branch delay slot |
| rd_idx | input | 5 | Register read index |
| rd_data | output | 32 | Read data (combinational) |
| rfe_i | input | 1 | Return-from-exception strobe (mode stack pop) |
| exc_enter_i | input | 1 | Exception-entry strobe (mode stack push) |
| exc_req_o | output | 1 | Software-interrupt exception request pulse |
| exc_slot_o | output | 1 | Delay-slot flag of the request |
| exc_cause_o | output | 32 | Current cause word |

## Verification
The bench sweeps every combination of the two software-pending bits, the two mask bits and the enable bit. A design that ignored the enable bit, or used OR instead of AND, would raise requests for unmasked or disabled combinations. All 64 patterns of the six stack bits are pushed and popped. A swapped shift or a dropped clear would corrupt the old mode pair or leak into bits 31..6. Simultaneous strobes and writes are driven to expose a wrong priority. Writing all ones to the cause word exposes a missing clear of bits 15..10. A full index sweep catches aliasing of unimplemented indices onto stored ones.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int XLEN  = 32;
    localparam int IDX_W = 5;

    localparam logic [IDX_W-1:0] IDX_STATUS = 5'd12;
    localparam logic [IDX_W-1:0] IDX_CAUSE  = 5'd13;

    // bits software may never set in the cause word
    localparam logic [XLEN-1:0] CAUSE_HW_MASK = 32'h0000_FC00;
    // software interrupt pending / mask bit pair
    localparam logic [XLEN-1:0] SWINT_MASK    = 32'h0000_0300;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } req_state_e;
endpackage

// File: rtl/sysctl_status_reg.sv
module sysctl_status_reg
    import sysctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hit,
    input  logic [XLEN-1:0] wr_data,
    input  logic            rfe,
    input  logic            exc_enter,
    output logic [XLEN-1:0] status_q
);
    logic [XLEN-1:0] status_d;

    // priority: exception push, then pop, then software write
    always_comb begin
        status_d = status_q;
        if (exc_enter) begin
            status_d = {status_q[XLEN-1:6], status_q[3:0], 2'b00};
        end else if (rfe) begin
            status_d = {status_q[XLEN-1:4], status_q[5:2]};
        end else if (wr_hit) begin
            status_d = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end
endmodule

// File: rtl/sysctl_cause_reg.sv
module sysctl_cause_reg
    import sysctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hit,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] cause_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)      cause_q <= '0;
        else if (wr_hit) cause_q <= wr_data & ~CAUSE_HW_MASK;
    end
endmodule

// File: rtl/sysctl_plain_store.sv
module sysctl_plain_store
    import sysctl_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_data
);
    localparam int CAP = (NUM_REGS > (1 << IDX_W)) ? (1 << IDX_W) : NUM_REGS;

    logic [XLEN-1:0] slot_q [CAP];

    for (genvar g = 0; g < CAP; g++) begin : g_slot
        if (g == int'(IDX_STATUS) || g == int'(IDX_CAUSE)) begin : g_hole
            assign slot_q[g] = '0;
        end else begin : g_reg
            logic [XLEN-1:0] val_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    val_q <= '0;
                else if (wr_en && (int'(wr_idx) == g))
                    val_q <= wr_data;
            end
            assign slot_q[g] = val_q;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < CAP; i++) begin
            if (int'(rd_idx) == i) rd_data = slot_q[i];
        end
    end
endmodule

// File: rtl/sysctl_swint_fsm.sv
module sysctl_swint_fsm
    import sysctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig,
    input  logic            slot_i,
    input  logic [XLEN-1:0] status,
    input  logic [XLEN-1:0] cause,
    output logic            req,
    output logic            req_slot
);
    req_state_e state_q, state_d;
    logic       slot_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (trig) state_d = ST_EVAL;    // T1
            ST_EVAL: state_d = trig ? ST_EVAL        // T2
                                    : ST_IDLE;       // T3
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (trig) slot_q <= slot_i;
        end
    end

    always_comb begin
        req      = 1'b0;
        req_slot = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_EVAL: begin
                req      = status[0] && ((status & cause & SWINT_MASK) != '0);
                req_slot = req && slot_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              slot_i,
    input  logic [4:0]        rd_idx,
    output logic [31:0]       rd_data,
    input  logic              rfe_i,
    input  logic              exc_enter_i,
    output logic              exc_req_o,
    output logic              exc_slot_o,
    output logic [31:0]       exc_cause_o
);
    logic            hit_status, hit_cause;
    logic [XLEN-1:0] status_q, cause_q, store_rd;

    assign hit_status = wr_en && (wr_idx == IDX_STATUS);
    assign hit_cause  = wr_en && (wr_idx == IDX_CAUSE);

    sysctl_status_reg u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (hit_status),
        .wr_data   (wr_data),
        .rfe       (rfe_i),
        .exc_enter (exc_enter_i),
        .status_q  (status_q)
    );

    sysctl_cause_reg u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (hit_cause),
        .wr_data (wr_data),
        .cause_q (cause_q)
    );

    sysctl_plain_store #(.NUM_REGS(NUM_REGS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (store_rd)
    );

    sysctl_swint_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (hit_status || hit_cause),
        .slot_i   (slot_i),
        .status   (status_q),
        .cause    (cause_q),
        .req      (exc_req_o),
        .req_slot (exc_slot_o)
    );

    always_comb begin
        unique case (rd_idx)
            IDX_STATUS: rd_data = status_q;
            IDX_CAUSE:  rd_data = cause_q;
            default:    rd_data = store_rd;
        endcase
    end

    assign exc_cause_o = cause_q;
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
    import sysctl_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [4:0]  wr_idx,
    input logic        rfe,
    input logic        exc_enter,
    input logic [31:0] status,
    input logic [31:0] cause,
    input logic        exc_req
);
    logic trig;
    assign trig = wr_en && (wr_idx == IDX_STATUS || wr_idx == IDX_CAUSE);

    // R8
    req_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> $past(trig));

    // R8
    req_condition_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (status[0] && ((status & cause & SWINT_MASK) != 32'd0)));

    // R10
    req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> !exc_req);

    // R3
    cause_hw_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause[15:10] == 6'd0);

    // R5
    mode_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe && !exc_enter) |=> (status[3:0] == $past(status[5:2]) &&
                                 status[31:4] == $past(status[31:4])));

    // R6
    mode_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (status[5:2] == $past(status[3:0]) && status[1:0] == 2'b00 &&
                       status[31:6] == $past(status[31:6])));
endmodule

bind sysctl_regs sysctl_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .rfe       (rfe_i),
    .exc_enter (exc_enter_i),
    .status    (status_q),
    .cause     (cause_q),
    .exc_req   (exc_req_o)
);

// File: tb/sysctl_regs_tb.sv
`timescale 1ns/1ps
module sysctl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        slot_i = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        rfe_i = 1'b0;
    logic        exc_enter_i = 1'b0;
    logic        exc_req_o, exc_slot_o;
    logic [31:0] exc_cause_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sysctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .slot_i(slot_i), .rd_idx(rd_idx), .rd_data(rd_data),
        .rfe_i(rfe_i), .exc_enter_i(exc_enter_i), .exc_req_o(exc_req_o),
        .exc_slot_o(exc_slot_o), .exc_cause_o(exc_cause_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] idx, output logic [31:0] v);
        rd_idx = idx;
        #0.5;
        v = rd_data;
    endtask

    // drives at a falling edge; returns at the next falling edge
    task automatic wr(input logic [4:0] idx, input logic [31:0] d, input logic s);
        wr_en = 1'b1; wr_idx = idx; wr_data = d; slot_i = s;
        @(negedge clk);
        wr_en = 1'b0; slot_i = 1'b0;
    endtask

    task automatic strobe(input logic r, input logic e);
        rfe_i = r; exc_enter_i = e;
        @(negedge clk);
        rfe_i = 1'b0; exc_enter_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, s0, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'd12, v); chk("R1 status", v, 32'h0);
        rd(5'd13, v); chk("R1 cause", v, 32'h0);
        rd(5'd3, v);  chk("R1 store", v, 32'h0);
        chk("R1 req", {31'd0, exc_req_o}, 32'd0);

        // R2 status write/read
        wr(5'd12, 32'h1234_56F0, 1'b0);
        rd(5'd12, v); chk("R2 status", v, 32'h1234_56F0);
        wr(5'd12, 32'hFFFF_FFFE, 1'b0);
        rd(5'd12, v); chk("R2 status ones", v, 32'hFFFF_FFFE);

        // R3 cause masking, R9 cause output
        wr(5'd13, 32'hFFFF_FFFF, 1'b0);
        rd(5'd13, v); chk("R3 cause", v, 32'hFFFF_03FF);
        chk("R9 cause out", exc_cause_o, 32'hFFFF_03FF);
        wr(5'd13, 32'h0000_FC00, 1'b0);
        rd(5'd13, v); chk("R3 cause hw bits", v, 32'h0);

        // R4 index sweep
        for (int i = 0; i < 32; i++)
            if (i != 12 && i != 13) wr(5'(i), 32'h5A00_0000 ^ (32'(i) * 32'h0101_0101), 1'b0);
        for (int i = 0; i < 32; i++) begin
            if (i == 12 || i == 13) continue;
            rd(5'(i), v);
            e = (i < 16) ? (32'h5A00_0000 ^ (32'(i) * 32'h0101_0101)) : 32'h0;
            chk("R4 index", v, e);
        end

        // R5 / R6 stack sweep over all six-bit patterns
        wr(5'd13, 32'h0, 1'b0);
        for (int p = 0; p < 64; p++) begin
            s0 = 32'hABCD_0000 | 32'(p);
            wr(5'd12, s0, 1'b0);
            strobe(1'b1, 1'b0);
            rd(5'd12, v);
            chk("R5 pop", v, (s0 & 32'hFFFF_FFF0) | ((s0 >> 2) & 32'hF));
            wr(5'd12, s0, 1'b0);
            strobe(1'b0, 1'b1);
            rd(5'd12, v);
            chk("R6 push", v, (s0 & 32'hFFFF_FFC0) | ((s0 & 32'hF) << 2));
        end

        // R7 priority
        s0 = 32'h0000_0025;
        wr(5'd12, s0, 1'b0);
        strobe(1'b1, 1'b1);
        rd(5'd12, v); chk("R7 push over pop", v, 32'h0000_0014);
        wr(5'd12, s0, 1'b0);
        rfe_i = 1'b1; wr(5'd12, 32'h7777_0000, 1'b0); rfe_i = 1'b0;
        rd(5'd12, v); chk("R7 pop over write", v, 32'h0000_0029);
        wr(5'd12, s0, 1'b0);
        exc_enter_i = 1'b1; wr(5'd12, 32'h7777_0000, 1'b0); exc_enter_i = 1'b0;
        rd(5'd12, v); chk("R7 push over write", v, 32'h0000_0014);
        @(negedge clk);

        // R8 / R9 / R10 request sweep
        for (int c = 0; c < 32; c++) begin
            logic [1:0] im, ip;
            logic ie, s, exp_req;
            im = c[1:0]; ie = c[2]; ip = c[4:3]; s = c[0] ^ c[4];
            exp_req = ie && ((im & ip) != 2'b00);
            wr(5'd12, 32'h0, 1'b0);
            chk("R8 status cleared", {31'd0, exc_req_o}, 32'd0);
            wr(5'd13, {22'd0, ip, 8'd0}, 1'b0);
            chk("R8 disabled", {31'd0, exc_req_o}, 32'd0);
            wr(5'd12, {22'd0, im, 7'd0, ie}, s);
            chk("R8 request", {31'd0, exc_req_o}, {31'd0, exp_req});
            chk("R9 slot", {31'd0, exc_slot_o}, {31'd0, exp_req && s});
            chk("R9 cause", exc_cause_o, {22'd0, ip, 8'd0});
            @(negedge clk);
            chk("R10 pulse end", {31'd0, exc_req_o}, 32'd0);
        end

        // R10 back-to-back writes keep the request
        wr(5'd13, 32'h0000_0100, 1'b0);
        wr(5'd12, 32'h0000_0101, 1'b1);
        chk("R10 first", {31'd0, exc_req_o}, 32'd1);
        wr(5'd12, 32'h0000_0101, 1'b0);
        chk("R10 second", {31'd0, exc_req_o}, 32'd1);
        chk("R9 second slot", {31'd0, exc_slot_o}, 32'd0);
        @(negedge clk);
        chk("R10 end", {31'd0, exc_req_o}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule